// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the slave-side status logic of a serial flash device on an SPI link in mode 0. It accepts three commands: one that arms writes, one that loads a new status byte, and one that streams the status byte back to the host. The serial clock, chip select, data input and write-protect pin are brought into the system clock domain through a synchronizer. Edges of the serial clock are found there, so the serial clock must run well below the system clock. A host SPI controller talks to it directly. The status byte it keeps is read by the rest of the flash to decide what is protected and whether an internal write is busy.

A status load is accepted only in these conditions:
- a write-enable command arrived earlier;
- the frame held exactly sixteen bits;
- hardware protection is off;
- no timed write is running.

An accepted load starts a busy period of a fixed number of system clocks. When that period ends, the write-enable flag clears.

Top module: `sfsr_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and the data-out enable `spi_miso_oe` is low.
- R2: Opcode 0x06 sets the write-enable flag, status bit 1, once its eighth bit is sampled.
- R3: Opcode 0x01 followed by one data byte changes the status only if bit 1 was set beforehand and chip select rises after exactly 16 sampled bits. A frame of 15 or 17 bits leaves the status unchanged.
- R4: An accepted status load copies data bits 7, 4, 3 and 2 into the same status positions, and the new values read back at once. Bits 1 and 0 are not taken from the data. Bits 6 and 5 always read 0.
- R5: When status bit 7 is 1 and `wp_n` is low, a status load is refused and the status is unchanged. With `wp_n` high the same load is accepted.
- R6: An accepted load starts a busy period of `TW_CYCLES` system clocks. Status bit 0 reads 1 during this period and 0 after it, and the status can be read throughout.
- R7: At the end of the busy period the write-enable flag, bit 1, clears.
- R8: Opcode 0x05 returns the status MSB first. A new bit is driven after each falling serial clock edge, starting with the falling edge that follows the opcode. The byte repeats while chip select stays low, and each repetition takes a fresh copy of the status.
- R9: `spi_miso_oe` is high only while a status read is being shifted out, and it drops once chip select is high.
- R10: Write-enable and status-load commands that arrive during the busy period have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low write-protect pin |
| spi_miso | output | 1 | Serial status data to the host |
| spi_miso_oe | output | 1 | Output driver enable; low means the line is high impedance |

## Verification
The bench sends frames of 15 and 17 bits. A design that counted bytes and not bits, or that acted on the last full byte, would take the load and set the protection bits.

The bench also sends loads and write-enables while the timed write is running. A design without the busy guard would change the protection bits or leave the write-enable flag set after the cycle.

Under hardware protection the load must be refused and must not start a busy period. A continuous read across the end of the busy period must show bit 0 falling within one frame. A controller that took one status copy per frame would keep showing the stale value.

A sweep over data bytes with every combination of the upper five bits checks that bits 6 and 5 stay zero. It also checks that the low two bits come only from the internal state.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;

  localparam int BYTE_W = 8;
  localparam int NB_W   = 5;

  localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;
  localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;

  localparam int BIT_WIP  = 0;
  localparam int BIT_WEL  = 1;
  localparam int BP_LSB   = 2;
  localparam int BP_W     = 3;
  localparam int BIT_SRWD = 7;

  // Assemble the visible status byte from its stored fields.
  function automatic logic [BYTE_W-1:0] pack_status(
    input logic          srwd,
    input logic [BP_W-1:0] bp,
    input logic          wel,
    input logic          wip
  );
    logic [BYTE_W-1:0] s;
    s                      = '0;
    s[BIT_SRWD]            = srwd;
    s[BP_LSB +: BP_W]      = bp;
    s[BIT_WEL]             = wel;
    s[BIT_WIP]             = wip;
    return s;
  endfunction

  // A status-load frame is the load opcode plus exactly one data byte.
  function automatic logic is_load_frame(
    input logic [BYTE_W-1:0] op,
    input logic [NB_W-1:0]   nbits
  );
    return (op == OP_WRSR) && (nbits == NB_W'(2 * BYTE_W));
  endfunction

  // Hardware lock: disable bit set while the protect pin is pulled low.
  function automatic logic hw_locked(input logic srwd, input logic wp_n);
    return srwd & ~wp_n;
  endfunction

endpackage

// File: rtl/sfsr_sync.sv
module sfsr_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[s] <= INIT;
        end else if (s == 0) begin
          stg_q[s] <= din;
        end else begin
          stg_q[s] <= stg_q[(s == 0) ? 0 : s - 1];
        end
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/sfsr_rx.sv
module sfsr_rx
  import sfsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              sample,
  input  logic              sdi,
  output logic [BYTE_W-1:0] op_q,
  output logic [BYTE_W-1:0] data_q,
  output logic [NB_W-1:0]   nbits_q,
  output logic              op_done_q
);

  localparam logic [NB_W-1:0] NB_MAX    = '1;
  localparam logic [NB_W-1:0] OP_LAST   = NB_W'(BYTE_W - 1);
  localparam logic [NB_W-1:0] DATA_LAST = NB_W'(2 * BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] sh_next;

  assign sh_next = {sh_q[BYTE_W-2:0], sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      op_q      <= '0;
      data_q    <= '0;
      nbits_q   <= '0;
      op_done_q <= 1'b0;
    end else begin
      op_done_q <= 1'b0;
      if (frame_start) begin
        nbits_q <= '0;
      end else if (sample) begin
        sh_q <= sh_next;
        if (nbits_q != NB_MAX) nbits_q <= nbits_q + 1'b1;
        if (nbits_q == OP_LAST) begin
          op_q      <= sh_next;
          op_done_q <= 1'b1;
        end
        if (nbits_q == DATA_LAST) data_q <= sh_next;
      end
    end
  end

endmodule

// File: rtl/sfsr_wtimer.sv
module sfsr_wtimer #(
  parameter int TW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int            CW   = $clog2(TW + 1);
  localparam logic [CW-1:0] LOAD = CW'(TW);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start && cnt_q == '0) begin
      cnt_q <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == LAST);

endmodule

// File: rtl/sfsr_tx.sv
module sfsr_tx
  import sfsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              stop,
  input  logic              shift,
  input  logic [BYTE_W-1:0] load_val,
  output logic              sdo_q,
  output logic              oe_q
);

  localparam int               IW       = $clog2(BYTE_W);
  localparam logic [IW-1:0]    IDX_LAST = IW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [IW-1:0]     idx_q;
  logic              armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      idx_q   <= '0;
      armed_q <= 1'b0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (stop) begin
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
      idx_q   <= '0;
      sdo_q   <= 1'b0;
    end else if (arm) begin
      armed_q <= 1'b1;
      idx_q   <= '0;
    end else if (shift && armed_q) begin
      oe_q <= 1'b1;
      if (idx_q == '0) begin
        sdo_q <= load_val[BYTE_W-1];
        sh_q  <= {load_val[BYTE_W-2:0], 1'b0};
      end else begin
        sdo_q <= sh_q[BYTE_W-1];
        sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
      end
      idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/sfsr_status_ctrl.sv
module sfsr_status_ctrl
  import sfsr_pkg::*;
#(
  parameter int TW_CYCLES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  input  logic wp_n,
  output logic spi_miso,
  output logic spi_miso_oe
);

  // Synchronized pin order: {wp_n, mosi, sck, cs_n}
  localparam int              NPIN     = 4;
  localparam logic [NPIN-1:0] PIN_INIT = 4'b1001;

  logic [NPIN-1:0] pins_raw, pins_s;
  logic sck_prev_q, cs_prev_q;

  // Named internal events, used by the checker.
  logic cs_hi_w, cs_rise_w, cs_fall_w;
  logic sck_rise_w, sck_fall_w;
  logic sample_w, shift_w;
  logic wren_hit_w, wr_commit_w, rd_arm_w;
  logic busy_w, wdone_w;
  logic [BYTE_W-1:0] status_w;

  logic [BYTE_W-1:0] op_q, data_q;
  logic [NB_W-1:0]   nbits_q;
  logic              op_done_q;

  logic            wel_q, srwd_q;
  logic [BP_W-1:0] bp_q;

  assign pins_raw = {wp_n, spi_mosi, spi_sck, spi_cs_n};

  sfsr_sync #(
    .WIDTH (NPIN),
    .STAGES(SYNC_STAGES),
    .INIT  (PIN_INIT)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pins_raw),
    .dout (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      cs_prev_q  <= 1'b1;
    end else begin
      sck_prev_q <= pins_s[1];
      cs_prev_q  <= pins_s[0];
    end
  end

  assign cs_hi_w    = pins_s[0];
  assign cs_rise_w  = pins_s[0] & ~cs_prev_q;
  assign cs_fall_w  = ~pins_s[0] & cs_prev_q;
  assign sck_rise_w = pins_s[1] & ~sck_prev_q;
  assign sck_fall_w = ~pins_s[1] & sck_prev_q;
  assign sample_w   = sck_rise_w & ~cs_hi_w;
  assign shift_w    = sck_fall_w & ~cs_hi_w;

  sfsr_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(cs_fall_w),
    .sample     (sample_w),
    .sdi        (pins_s[2]),
    .op_q       (op_q),
    .data_q     (data_q),
    .nbits_q    (nbits_q),
    .op_done_q  (op_done_q)
  );

  sfsr_wtimer #(.TW(TW_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(wr_commit_w),
    .busy (busy_w),
    .done (wdone_w)
  );

  assign wren_hit_w  = op_done_q && (op_q == OP_WREN) && !busy_w;
  assign rd_arm_w    = op_done_q && (op_q == OP_RDSR);
  assign wr_commit_w = cs_rise_w && is_load_frame(op_q, nbits_q) && wel_q &&
                       !busy_w && !hw_locked(srwd_q, pins_s[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      srwd_q <= 1'b0;
      bp_q   <= '0;
    end else begin
      if (wdone_w)         wel_q <= 1'b0;
      else if (wren_hit_w) wel_q <= 1'b1;
      if (wr_commit_w) begin
        srwd_q <= data_q[BIT_SRWD];
        bp_q   <= data_q[BP_LSB +: BP_W];
      end
    end
  end

  assign status_w = pack_status(srwd_q, bp_q, wel_q, busy_w);

  sfsr_tx u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (rd_arm_w),
    .stop    (cs_hi_w),
    .shift   (shift_w),
    .load_val(status_w),
    .sdo_q   (spi_miso),
    .oe_q    (spi_miso_oe)
  );

endmodule

// File: rtl/sfsr_status_chk.sv
module sfsr_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_hi,
  input logic       wr_commit,
  input logic       wren_hit,
  input logic       wdone,
  input logic       busy,
  input logic [7:0] status,
  input logic       miso_oe
);

  // R6: an accepted load starts the busy period
  a_r6_commit_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> busy);

  // R6: busy holds until the terminal count
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wdone) |=> busy);

  // R7: end of the busy period clears the enable flag
  a_r7_done_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    wdone |=> !status[1]);

  // R2: a decoded enable command sets bit 1
  a_r2_wren_sets_wel: assert property (@(posedge clk) disable iff (!rst_n)
    wren_hit |=> status[1]);

  // R4: protection bits move only on an accepted load
  a_r4_bits_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(status[7:2]));

  // R9: driver off while chip select is high
  a_r9_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !miso_oe);

endmodule

bind sfsr_status_ctrl sfsr_status_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_hi    (cs_hi_w),
  .wr_commit(wr_commit_w),
  .wren_hit (wren_hit_w),
  .wdone    (wdone_w),
  .busy     (busy_w),
  .status   (status_w),
  .miso_oe  (spi_miso_oe)
);

// File: tb/sim_sfsr_status_ctrl.sv
module sim_sfsr_status_ctrl;

  localparam int CLK_NS = 10;
  localparam int HALF   = 8;
  localparam int TW     = 600;
  localparam int WDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso, miso_oe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  sfsr_status_ctrl #(.TW_CYCLES(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .wp_n(wp_n), .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Shift n bits MSB first while chip select is low; miso captured before each rise.
  task automatic spi_bits(input logic [31:0] val, input int n, output logic [31:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = val[i];
      wait_clk(HALF);
      rx = {rx[30:0], miso};
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_high();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic frame(input logic [31:0] val, input int n);
    logic [31:0] rx;
    cs_low();
    spi_bits(val, n, rx);
    cs_high();
  endtask

  task automatic read_status(output logic [7:0] st);
    logic [31:0] rx;
    cs_low();
    spi_bits({24'h0, 8'h05}, 8, rx);
    spi_bits(32'h0, 8, rx);
    cs_high();
    st = rx[7:0];
  endtask

  task automatic wren();
    frame(32'h06, 8);
  endtask

  task automatic wrsr(input logic [7:0] d);
    frame({16'h0, 8'h01, d}, 16);
  endtask

  initial begin : watchdog
    wait_clk(WDOG);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0]  st;
    logic [31:0] rx;
    logic [7:0]  exp_b;
    bit          saw_busy;

    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1 / R9: reset state
    check(miso_oe == 1'b0, "R9 idle oe", {31'h0, miso_oe}, 32'h0);
    read_status(st);
    check(st == 8'h00, "R1 reset status", {24'h0, st}, 32'h00);

    // R3: load without prior enable is ignored
    wrsr(8'h9C);
    read_status(st);
    check(st == 8'h00, "R3 no enable", {24'h0, st}, 32'h00);

    // R2: enable sets bit 1
    wren();
    read_status(st);
    check(st == 8'h02, "R2 enable", {24'h0, st}, 32'h02);

    // R3: wrong frame lengths
    frame({17'h0, 8'h01, 7'h7F}, 15);
    read_status(st);
    check(st == 8'h02, "R3 15 bits", {24'h0, st}, 32'h02);
    frame({15'h0, 8'h01, 8'hFF, 1'b1}, 17);
    read_status(st);
    check(st == 8'h02, "R3 17 bits", {24'h0, st}, 32'h02);

    // R4 / R6 / R7: valid load, busy, then enable cleared
    wrsr(8'hFF);
    read_status(st);
    check(st == 8'h9F, "R6 busy read R4 mask", {24'h0, st}, 32'h9F);
    wait_clk(TW + 20);
    read_status(st);
    check(st == 8'h9C, "R7 enable cleared", {24'h0, st}, 32'h9C);

    // R5: hardware protection
    wp_n = 1'b0;
    wren();
    wrsr(8'h00);
    read_status(st);
    check(st == 8'h9E, "R5 locked", {24'h0, st}, 32'h9E);
    wp_n = 1'b1;
    wait_clk(4);
    wrsr(8'h00);
    read_status(st);
    check(st == 8'h03, "R5 unlocked", {24'h0, st}, 32'h03);
    wait_clk(TW + 20);
    read_status(st);
    check(st == 8'h00, "R7 after unlocked load", {24'h0, st}, 32'h00);

    // R10: commands during busy have no effect
    wren();
    wrsr(8'h10);
    wrsr(8'h0C);
    wren();
    wait_clk(TW + 20);
    read_status(st);
    check(st == 8'h10, "R10 busy ignore", {24'h0, st}, 32'h10);

    // R8 / R6: continuous polling within one frame
    wren();
    wrsr(8'h04);
    cs_low();
    spi_bits({24'h0, 8'h05}, 8, rx);
    spi_bits(32'h0, 8, rx);
    check(rx[7:0] == 8'h07, "R8 first poll byte", {24'h0, rx[7:0]}, 32'h07);
    saw_busy = 1'b1;
    for (int k = 0; k < 12 && saw_busy; k++) begin
      spi_bits(32'h0, 8, rx);
      saw_busy = rx[0];
    end
    cs_high();
    check(rx[7:0] == 8'h04, "R8 poll sees end", {24'h0, rx[7:0]}, 32'h04);

    // R8 / R9: repeated bytes in one frame, driver state
    cs_low();
    spi_bits({24'h0, 8'h05}, 8, rx);
    spi_bits(32'h0, 24, rx);
    check(miso_oe == 1'b1, "R9 oe during read", {31'h0, miso_oe}, 32'h1);
    check(rx[23:0] == 24'h040404, "R8 repeat", {8'h0, rx[23:0]}, 32'h040404);
    cs_high();
    check(miso_oe == 1'b0, "R9 oe after read", {31'h0, miso_oe}, 32'h0);

    // R4: sweep of data bytes
    for (int i = 0; i < 32; i++) begin
      logic [7:0] d;
      d = 8'((i * 8) | (i % 8));
      wren();
      wrsr(d);
      wait_clk(TW + 20);
      read_status(st);
      exp_b = d & 8'h9C;
      check(st == exp_b, "R4 sweep", {24'h0, st}, {24'h0, exp_b});
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule